// File: doc/BRIEF.md
# Wakeup Event Latch Controller

This block collects asynchronous wakeup sources and turns them into a single wake request for a power controller. The sources fall into three groups. The first is external pin sources, which include two lines derived from an SD card data bus. The second is peripheral interrupt sources. The third is a wide bank of general-purpose port sources. Every source first passes through a two-flop synchroniser on the always-on clock that also runs the rest of the block. The block therefore keeps working while the main system clock is stopped.

For the pin and interrupt groups, the block detects a selectable edge on each source. Each detected edge is latched in a raw status bit. A status bit latches whether or not its source is enabled. The enable registers only control whether a latched bit asserts `wake_req`. The port group has no polarity and no status of its own. Its enabled, active sources are ORed into one aggregate line. That line is treated as one member of the interrupt group, so it has the interrupt group's polarity, status and enable. Software reaches the registers through a simple word-addressed bus with a read strobe and a read-valid response. It clears status by writing ones back.

Top module: `wake_latch_ctrl`

## Requirements
- R1: After reset, all three enable registers and both status registers read 0, and the pin polarity register reads 0 (falling edge everywhere). The interrupt polarity register reads its reset mask, 0x00001202 (bits 1, 9 and 12 rising). `wake_req` is 0.
- R2: The register word offsets are 0 pin enable, 1 pin polarity, 2 pin status, 3 interrupt enable, 4 interrupt polarity, 5 interrupt status and 6 port enable. A read strobe gives `rd_valid` high with `rdata` on the next cycle only.
- R3: A pin or interrupt source whose polarity bit is 1 sets its status bit on a rising edge, and on a falling edge when the bit is 0. The opposite edge leaves the status bit unchanged. A status bit latches even while its enable bit is 0.
- R4: Writing 1 to a status bit clears it and writing 0 leaves it set. If an edge is detected in the same cycle as the clearing write, the bit stays set.
- R5: `wake_req` is high exactly when some status bit is set together with its enable bit (one register stage later). Clearing that status bit or its enable drops `wake_req`.
- R6: Interrupt-group bit 6 is the port aggregate. Its level is high when any port source is high with its enable bit set. Interrupt-group bits below 6 come from `irq_in` bits of the same index, and bits above 6 come from `irq_in[i-1]`. The aggregate follows the interrupt polarity, status and enable of bit 6, so with interrupt enable bit 6 at 0 it sets status but never asserts `wake_req`.
- R7: A port source whose port enable bit is 0 has no effect on the interrupt status.
- R8: Pin-group bit 22 is the OR of all four `sd_data` lines. Pin-group bit 23 is `sd_data[1]` alone. Pin bits 0 to 21 come from `pin_in`.
- R9: Offset 7, the place where a port polarity register would sit, accepts no writes: a write there changes no register, and it reads as 0.
- R10: A status bit is never set by a register write, only by a detected edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-frequency clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe, one cycle after rd_en |
| pin_in | input | 22 | Asynchronous pin sources |
| sd_data | input | 4 | SD card data lines |
| irq_in | input | 19 | Asynchronous peripheral interrupt sources |
| port_in | input | 32 | Asynchronous general-purpose port sources |
| wake_req | output | 1 | Wake request to the power controller |

## Verification
The assertions assume the following about the inputs:
- Register strobes are synchronous to `clk`.
- At most one write occurs per cycle.
- The source inputs are quiet while reset is applied, so no edge is implied by the reset values of the synchroniser flops.

The stimulus drives every strobe on the falling clock edge and holds source levels for several cycles so each one passes the synchronisers. It leaves all sources low through reset. Each pulse stays high long enough for both of its edges to be seen separately.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    OFS_PIN_EN   = 3'd0,
    OFS_PIN_POL  = 3'd1,
    OFS_PIN_STAT = 3'd2,
    OFS_IRQ_EN   = 3'd3,
    OFS_IRQ_POL  = 3'd4,
    OFS_IRQ_STAT = 3'd5,
    OFS_PORT_EN  = 3'd6,
    OFS_HOLE     = 3'd7
  } reg_ofs_e;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wk_edge_latch.sv
module wk_edge_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] ev,
  output logic [W-1:0] stat
);
  logic [W-1:0] prev;

  for (genvar i = 0; i < W; i++) begin : g_edge
    // polarity 1: low-to-high; polarity 0: high-to-low
    assign ev[i] = pol[i] ? (lvl[i] & ~prev[i]) : (~lvl[i] & prev[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      stat <= '0;
    end else begin
      prev <= lvl;
      stat <= (stat & ~clr) | ev;
    end
  end
endmodule

// File: rtl/wake_latch_ctrl.sv
module wake_latch_ctrl #(
  parameter int unsigned DW          = 32,
  parameter int unsigned PIN_W       = 24,
  parameter int unsigned SD_W        = 4,
  parameter int unsigned IRQ_W       = 20,
  parameter int unsigned PORT_W      = 32,
  parameter int unsigned AGG_BIT     = 6,
  parameter logic [31:0] IRQ_POL_RST = 32'h0000_1202
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [wk_pkg::REG_AW-1:0] addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  output logic                    rd_valid,
  input  logic [PIN_W-3:0]        pin_in,
  input  logic [SD_W-1:0]         sd_data,
  input  logic [IRQ_W-2:0]        irq_in,
  input  logic [PORT_W-1:0]       port_in,
  output logic                    wake_req
);
  import wk_pkg::*;

  localparam int unsigned PIN_RAW = PIN_W - 2;

  logic [PIN_W-1:0]  pin_en_q, pin_pol_q, pin_stat, pin_ev, pin_clr, pin_lvl;
  logic [IRQ_W-1:0]  irq_en_q, irq_pol_q, irq_stat, irq_ev, irq_clr, irq_lvl;
  logic [PORT_W-1:0] port_en_q, port_sync;
  logic [PIN_W-1:0]  pin_raw;
  logic [IRQ_W-2:0]  irq_sync;
  logic              port_agg;
  reg_ofs_e          ofs;

  assign ofs = reg_ofs_e'(addr);

  // pin group: plain pins, then SD data OR, then SD line 1 alone
  assign pin_raw = {sd_data[1], |sd_data, pin_in};

  wk_sync #(.W(PIN_W))     u_pin_sync  (.clk(clk), .rst(rst), .d(pin_raw), .q(pin_lvl));
  wk_sync #(.W(IRQ_W-1))   u_irq_sync  (.clk(clk), .rst(rst), .d(irq_in),  .q(irq_sync));
  wk_sync #(.W(PORT_W))    u_port_sync (.clk(clk), .rst(rst), .d(port_in), .q(port_sync));

  assign port_agg = |(port_sync & port_en_q);

  // interrupt level vector with the port aggregate spliced in at AGG_BIT
  for (genvar i = 0; i < IRQ_W; i++) begin : g_irq_map
    if (i < AGG_BIT) begin : g_lo
      assign irq_lvl[i] = irq_sync[i];
    end else if (i == AGG_BIT) begin : g_agg
      assign irq_lvl[i] = port_agg;
    end else begin : g_hi
      assign irq_lvl[i] = irq_sync[i-1];
    end
  end

  assign pin_clr = (wr_en && ofs == OFS_PIN_STAT) ? wdata[PIN_W-1:0] : '0;
  assign irq_clr = (wr_en && ofs == OFS_IRQ_STAT) ? wdata[IRQ_W-1:0] : '0;

  wk_edge_latch #(.W(PIN_W)) u_pin_edge (
    .clk(clk), .rst(rst), .lvl(pin_lvl), .pol(pin_pol_q),
    .clr(pin_clr), .ev(pin_ev), .stat(pin_stat)
  );

  wk_edge_latch #(.W(IRQ_W)) u_irq_edge (
    .clk(clk), .rst(rst), .lvl(irq_lvl), .pol(irq_pol_q),
    .clr(irq_clr), .ev(irq_ev), .stat(irq_stat)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_en_q  <= '0;
      pin_pol_q <= '0;
      irq_en_q  <= '0;
      irq_pol_q <= IRQ_POL_RST[IRQ_W-1:0];
      port_en_q <= '0;
    end else if (wr_en) begin
      unique case (ofs)
        OFS_PIN_EN:  pin_en_q  <= wdata[PIN_W-1:0];
        OFS_PIN_POL: pin_pol_q <= wdata[PIN_W-1:0];
        OFS_IRQ_EN:  irq_en_q  <= wdata[IRQ_W-1:0];
        OFS_IRQ_POL: irq_pol_q <= wdata[IRQ_W-1:0];
        OFS_PORT_EN: port_en_q <= wdata[PORT_W-1:0];
        default: ;
      endcase
    end
  end

  // read path, one cycle latency
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (ofs)
      OFS_PIN_EN:   rd_mux[PIN_W-1:0]  = pin_en_q;
      OFS_PIN_POL:  rd_mux[PIN_W-1:0]  = pin_pol_q;
      OFS_PIN_STAT: rd_mux[PIN_W-1:0]  = pin_stat;
      OFS_IRQ_EN:   rd_mux[IRQ_W-1:0]  = irq_en_q;
      OFS_IRQ_POL:  rd_mux[IRQ_W-1:0]  = irq_pol_q;
      OFS_IRQ_STAT: rd_mux[IRQ_W-1:0]  = irq_stat;
      OFS_PORT_EN:  rd_mux[PORT_W-1:0] = port_en_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      rdata    <= rd_en ? rd_mux : '0;
      rd_valid <= rd_en;
      wake_req <= |(pin_stat & pin_en_q) | |(irq_stat & irq_en_q);
    end
  end
endmodule

// File: rtl/wk_chk.sv
module wk_chk #(
  parameter int unsigned PIN_W  = 24,
  parameter int unsigned IRQ_W  = 20,
  parameter int unsigned PORT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [2:0]        addr,
  input logic [PIN_W-1:0]  pin_en_q,
  input logic [PIN_W-1:0]  pin_pol_q,
  input logic [PIN_W-1:0]  pin_stat,
  input logic [PIN_W-1:0]  pin_ev,
  input logic [IRQ_W-1:0]  irq_en_q,
  input logic [IRQ_W-1:0]  irq_pol_q,
  input logic [IRQ_W-1:0]  irq_stat,
  input logic [IRQ_W-1:0]  irq_ev,
  input logic [PORT_W-1:0] port_en_q,
  input logic              wake_req
);
  // R2
  rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R5
  wake_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_en_q == '0 && irq_en_q == '0) |=> !wake_req);

  // R10
  pin_set_by_edge_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_stat & ~$past(pin_stat) & ~$past(pin_ev)) == '0));

  // R10
  irq_set_by_edge_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_stat & ~$past(irq_stat) & ~$past(irq_ev)) == '0));

  // R9
  hole_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd7) |=> ($stable(pin_en_q) && $stable(pin_pol_q) &&
      $stable(irq_en_q) && $stable(irq_pol_q) && $stable(port_en_q)));

  // R4
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_ev != '0) |=> ((pin_stat & $past(pin_ev)) == $past(pin_ev)));
endmodule

bind wake_latch_ctrl wk_chk #(.PIN_W(PIN_W), .IRQ_W(IRQ_W), .PORT_W(PORT_W)) u_wk_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_valid(rd_valid),
  .addr(addr), .pin_en_q(pin_en_q), .pin_pol_q(pin_pol_q), .pin_stat(pin_stat),
  .pin_ev(pin_ev), .irq_en_q(irq_en_q), .irq_pol_q(irq_pol_q),
  .irq_stat(irq_stat), .irq_ev(irq_ev), .port_en_q(port_en_q),
  .wake_req(wake_req)
);

// File: tb/wake_latch_ctrl_test.sv
module wake_latch_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic [21:0] pin_in = '0;
  logic [3:0]  sd_data = '0;
  logic [18:0] irq_in = '0;
  logic [31:0] port_in = '0;
  logic        wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] q_exp[$];
  string       q_req[$];

  always #2 clk = ~clk;

  wake_latch_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .pin_in(pin_in),
    .sd_data(sd_data), .irq_in(irq_in), .port_in(port_in), .wake_req(wake_req)
  );

  // monitor: compares read responses against the scoreboard queue
  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (q_exp.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected read response %h (expected none)", rdata);
      end else begin
        logic [31:0] e;
        string       r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: read got %h expected %h", r, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string r);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    q_exp.push_back(e);
    q_req.push_back(r);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic chk_wake(input logic e, input string r);
    @(negedge clk);
    checks++;
    if (wake_req !== e) begin
      errors++;
      $display("FAIL %s: wake_req got %b expected %b", r, wake_req, e);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete (got hang, expected finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 / R2 reset values and map
    chk_wake(1'b0, "R1");
    rd(3'd0, 32'h0, "R1");
    rd(3'd1, 32'h0, "R1");
    rd(3'd2, 32'h0, "R1");
    rd(3'd3, 32'h0, "R1");
    rd(3'd4, 32'h0000_1202, "R1");
    rd(3'd5, 32'h0, "R1");
    rd(3'd6, 32'h0, "R2");

    // R3 falling-edge default: rise ignored, fall latched while disabled
    pin_in[3] = 1'b1; settle();
    rd(3'd2, 32'h0, "R3");
    pin_in[3] = 1'b0; settle();
    rd(3'd2, 32'h8, "R3");
    chk_wake(1'b0, "R5");

    // R5 enable then W1C
    wr(3'd0, 32'h8); settle();
    chk_wake(1'b1, "R5");
    wr(3'd2, 32'h0); settle();
    rd(3'd2, 32'h8, "R4");
    wr(3'd2, 32'hFFFF_FFFF); settle();
    rd(3'd2, 32'h0, "R10");
    chk_wake(1'b0, "R5");
    wr(3'd0, 32'h0);

    // R3 rising polarity on pin 5
    wr(3'd1, 32'h20);
    pin_in[5] = 1'b1; settle();
    pin_in[5] = 1'b0; settle();
    rd(3'd2, 32'h20, "R3");
    wr(3'd2, 32'h20);

    // R4 edge in the same cycle as a clearing write
    @(negedge clk); pin_in[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 3'd2; wdata = 32'h20;
    @(negedge clk); wr_en = 1'b0;
    rd(3'd2, 32'h20, "R4");
    pin_in[5] = 1'b0; wr(3'd2, 32'h20); settle();

    // R3/R6 interrupt group mapping and default polarity
    irq_in[1] = 1'b1; irq_in[0] = 1'b1; settle();
    irq_in[1] = 1'b0; settle();
    rd(3'd5, 32'h2, "R3");
    irq_in[0] = 1'b0; settle();
    rd(3'd5, 32'h3, "R3");
    wr(3'd3, 32'h1); settle();
    chk_wake(1'b1, "R5");
    wr(3'd5, 32'h3); wr(3'd3, 32'h0); settle();
    chk_wake(1'b0, "R5");
    irq_in[8] = 1'b1; settle();
    irq_in[8] = 1'b0; settle();
    rd(3'd5, 32'h200, "R6");
    wr(3'd5, 32'h200);

    // R7 / R6 port aggregate
    wr(3'd4, 32'h0000_1242);
    port_in[4] = 1'b1; settle();
    rd(3'd5, 32'h0, "R7");
    wr(3'd6, 32'h10); settle();
    rd(3'd5, 32'h40, "R6");
    chk_wake(1'b0, "R6");
    wr(3'd3, 32'h40); settle();
    chk_wake(1'b1, "R6");
    wr(3'd3, 32'h0); port_in[4] = 1'b0; settle();
    wr(3'd5, 32'hFFFFF); settle();
    rd(3'd5, 32'h0, "R4");

    // R8 SD lines
    wr(3'd1, 32'h00C0_0000);
    sd_data[2] = 1'b1; settle();
    rd(3'd2, 32'h0040_0000, "R8");
    wr(3'd2, 32'h00C0_0000);
    sd_data[2] = 1'b0; settle();
    sd_data[1] = 1'b1; settle();
    rd(3'd2, 32'h00C0_0000, "R8");
    sd_data[1] = 1'b0;

    // R9 hole offset
    wr(3'd7, 32'hFFFF_FFFF); settle();
    rd(3'd7, 32'h0, "R9");
    rd(3'd1, 32'h00C0_0000, "R9");
    rd(3'd4, 32'h0000_1242, "R9");
    rd(3'd6, 32'h10, "R9");
    rd(3'd0, 32'h0, "R9");
    rd(3'd3, 32'h0, "R9");

    repeat (4) @(negedge clk);
    if (q_exp.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d reads unanswered (expected 0)", q_exp.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule